// File: doc/BRIEF.md
# Conversion Result Window Monitor

This block sits beside a conversion sequencer and checks every finished conversion result against a programmable window. The window has a lower and an upper bound. Each completion strobe carries a 12-bit raw result, the number of the channel it came from, and a bit saying whether the conversion was regular or injected. When a monitored result falls outside the window, the block sets a sticky out-of-window flag. If interrupts are enabled, it also pulses an interrupt request for one cycle.

Software sets up the monitor through a small word-wide register port. This port writes the two bounds and a control word. The control word chooses which conversion kinds are watched, whether one channel or every channel is watched, the guarded channel, and whether interrupts are raised. Software also reads the flag and clears it through the same port. The compare uses the raw result as it comes from the sequencer, so output alignment plays no part in it.

Top module: `conv_window_guard`

## Requirements
- R1: After reset the flag and the interrupt output are 0. The lower bound reads 0 and the upper bound reads all ones (4095). The control word reads 0, so nothing is monitored.
- R2: A write with `reg_wr` high stores `reg_wdata` in the addressed register. Address 0 is the lower bound and address 1 the upper bound, both in bits [11:0]. Address 2 is the control word: bit0 watches regular conversions, bit1 watches injected ones, bit2 watches every channel, bit3 enables interrupts, and bits [7:4] give the guarded channel. `reg_rdata` shows the addressed register in the same cycle.
- R3: A monitored result that is strictly below the lower bound, or strictly above the upper bound, sets the flag. The flag is visible on the clock edge that follows the strobe. A result equal to either bound is inside the window.
- R4: Once set, the flag stays set, whatever in-window results arrive later.
- R5: Writing 1 to bit0 at address 3 clears the flag. Writing 0 there has no effect. If a clear and a flag-setting result come in the same cycle, the flag ends up set.
- R6: `wd_irq` is high for exactly the one cycle after each out-of-window monitored result, and only when control bit3 is 1.
- R7: With control bit2 = 0, only results whose channel equals control bits [7:4] are monitored. With bit2 = 1, results from every channel are monitored.
- R8: A result with `res_inj` = 0 is monitored only when control bit0 = 1. A result with `res_inj` = 1 is monitored only when control bit1 = 1.
- R9: If the lower bound is greater than the upper bound, every monitored result sets the flag.
- R10: Reading address 3 returns the flag in bit0, with the other bits 0.
- R11: Result data presented while `res_valid` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid | input | 1 | Completion strobe from the sequencer |
| res_data | input | 12 | Raw conversion result |
| res_chan | input | 4 | Channel number of the result |
| res_inj | input | 1 | 1 = injected conversion, 0 = regular |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 12 | Read data of the addressed register |
| wd_flag | output | 1 | Sticky out-of-window flag |
| wd_irq | output | 1 | One-cycle interrupt request |

## Verification
Every one of the 4096 result codes is swept through three windows:
- A wide normal window (100..3000) separates the below, inside and above regions and both bound values.
- A window whose bounds are equal (2000..2000) shows that equality counts as inside, while the codes one step away on either side flag.
- An inverted window (3000..100) shows that every code flags.

Directed patterns then vary the conversion kind, the channel against the guarded channel, the interrupt enable, the strobe, and the timing of a clear against a set. These show that the filters select correctly, that the flag is sticky, and that a set wins over a clear.

// File: rtl/wg_pkg.sv
package wg_pkg;
    localparam int ADDR_W = 2;
    localparam int MODE_W = 4;

    localparam logic [ADDR_W-1:0] A_LOW  = 2'd0;
    localparam logic [ADDR_W-1:0] A_HIGH = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd3;

    // Packed so that mon_reg is bit0 of the control word.
    typedef struct packed {
        logic irq_en;
        logic all_chan;
        logic mon_inj;
        logic mon_reg;
    } wg_mode_t;
endpackage

// File: rtl/wg_regs.sv
module wg_regs #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 4,
    parameter int REG_W  = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      reg_wr,
    input  logic [wg_pkg::ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]          reg_wdata,
    input  logic                      flag_i,
    output logic [DATA_W-1:0]         lo_thr,
    output logic [DATA_W-1:0]         hi_thr,
    output wg_pkg::wg_mode_t          mode,
    output logic [CHAN_W-1:0]         chan_sel,
    output logic                      clr_req,
    output logic [REG_W-1:0]          reg_rdata
);
    import wg_pkg::*;

    typedef struct packed {
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
        wg_mode_t          mode;
        logic [CHAN_W-1:0] sel;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr) begin
            case (reg_addr)
                A_LOW:  cfg_d.lo = reg_wdata[DATA_W-1:0];
                A_HIGH: cfg_d.hi = reg_wdata[DATA_W-1:0];
                A_CTRL: begin
                    cfg_d.mode = reg_wdata[MODE_W-1:0];
                    cfg_d.sel  = reg_wdata[MODE_W +: CHAN_W];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.lo   <= '0;
            cfg_q.hi   <= '1;
            cfg_q.mode <= '0;
            cfg_q.sel  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_LOW:  reg_rdata[DATA_W-1:0] = cfg_q.lo;
            A_HIGH: reg_rdata[DATA_W-1:0] = cfg_q.hi;
            A_CTRL: begin
                reg_rdata[MODE_W-1:0]       = cfg_q.mode;
                reg_rdata[MODE_W +: CHAN_W] = cfg_q.sel;
            end
            default: reg_rdata[0] = flag_i;
        endcase
    end

    assign clr_req  = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];
    assign lo_thr   = cfg_q.lo;
    assign hi_thr   = cfg_q.hi;
    assign mode     = cfg_q.mode;
    assign chan_sel = cfg_q.sel;
endmodule

// File: rtl/wg_window.sv
module wg_window #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 4
) (
    input  logic              valid,
    input  logic [DATA_W-1:0] data,
    input  logic [CHAN_W-1:0] chan,
    input  logic              inj,
    input  logic [DATA_W-1:0] lo_thr,
    input  logic [DATA_W-1:0] hi_thr,
    input  wg_pkg::wg_mode_t  mode,
    input  logic [CHAN_W-1:0] chan_sel,
    output logic              hit
);
    logic kind_ok, chan_ok, outside;

    always_comb begin
        kind_ok = inj ? mode.mon_inj : mode.mon_reg;
        chan_ok = mode.all_chan || (chan == chan_sel);
        // Bounds are inclusive; an inverted window makes every code outside.
        outside = (data < lo_thr) || (data > hi_thr);
        hit     = valid && kind_ok && chan_ok && outside;
    end
endmodule

// File: rtl/conv_window_guard.sv
module conv_window_guard #(
    parameter  int DATA_W = 12,
    parameter  int CHAN_W = 4,
    localparam int REG_W  = (DATA_W > wg_pkg::MODE_W + CHAN_W) ? DATA_W
                                                              : wg_pkg::MODE_W + CHAN_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      res_valid,
    input  logic [DATA_W-1:0]         res_data,
    input  logic [CHAN_W-1:0]         res_chan,
    input  logic                      res_inj,
    input  logic                      reg_wr,
    input  logic [wg_pkg::ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    output logic                      wd_flag,
    output logic                      wd_irq
);
    import wg_pkg::*;

    typedef struct packed {
        logic flag;
        logic irq;
    } evt_t;

    evt_t              evt_d, evt_q;
    logic [DATA_W-1:0] lo_thr, hi_thr;
    wg_mode_t          mode;
    logic [CHAN_W-1:0] chan_sel;
    logic              clr_req, hit;

    wg_regs #(.DATA_W(DATA_W), .CHAN_W(CHAN_W), .REG_W(REG_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .flag_i   (evt_q.flag),
        .lo_thr   (lo_thr),
        .hi_thr   (hi_thr),
        .mode     (mode),
        .chan_sel (chan_sel),
        .clr_req  (clr_req),
        .reg_rdata(reg_rdata)
    );

    wg_window #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_window (
        .valid   (res_valid),
        .data    (res_data),
        .chan    (res_chan),
        .inj     (res_inj),
        .lo_thr  (lo_thr),
        .hi_thr  (hi_thr),
        .mode    (mode),
        .chan_sel(chan_sel),
        .hit     (hit)
    );

    always_comb begin
        evt_d = evt_q;
        // A new event wins over a clear in the same cycle.
        evt_d.flag = hit | (evt_q.flag & ~clr_req);
        evt_d.irq  = hit & mode.irq_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_q <= '0;
        end else begin
            evt_q <= evt_d;
        end
    end

    assign wd_flag = evt_q.flag;
    assign wd_irq  = evt_q.irq;
endmodule

// File: rtl/wg_chk.sv
module wg_chk #(
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              res_valid,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wdata0,
    input logic              wd_flag,
    input logic              wd_irq
);
    // R1
    always @(negedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!wd_flag && !wd_irq)
                else $error("flag or irq active in reset");
        end
    end

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !(reg_wr && reg_addr == 2'd3 && wdata0)) |=> wd_flag);

    // R3
    flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_flag) |-> $past(res_valid));

    // R6
    irq_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> wd_flag);

    // R11
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_irq |-> $past(res_valid));
endmodule

bind conv_window_guard wg_chk #(.ADDR_W(wg_pkg::ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .res_valid(res_valid),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .wdata0   (reg_wdata[0]),
    .wd_flag  (wd_flag),
    .wd_irq   (wd_irq)
);

// File: tb/conv_window_guard_bench.sv
module conv_window_guard_bench;
    localparam int DW = 12;
    localparam int CW = 4;
    localparam int RW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          res_valid = 1'b0;
    logic [DW-1:0] res_data = '0;
    logic [CW-1:0] res_chan = '0;
    logic          res_inj = 1'b0;
    logic          reg_wr = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [RW-1:0] reg_wdata = '0;
    logic [RW-1:0] reg_rdata;
    logic          wd_flag, wd_irq;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    conv_window_guard #(.DATA_W(DW), .CHAN_W(CW)) u_conv_window_guard (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .res_inj(res_inj), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .wd_flag(wd_flag), .wd_irq(wd_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [RW-1:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [RW-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic send(input logic [DW-1:0] d, input logic [CW-1:0] c, input logic inj);
        @(negedge clk);
        res_valid = 1'b1; res_data = d; res_chan = c; res_inj = inj;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    function automatic logic [RW-1:0] ctrl(input logic mr, input logic mi,
                                           input logic all, input logic ie,
                                           input logic [CW-1:0] sel);
        return {sel, ie, all, mi, mr};
    endfunction

    task automatic sweep(input int lo, input int hi, input string tag);
        wr(2'd0, RW'(lo));
        wr(2'd1, RW'(hi));
        wr(2'd3, 12'h001);
        for (int v = 0; v < 4096; v++) begin
            logic e;
            e = (v < lo) || (v > hi);
            send(DW'(v), 4'd0, 1'b0);
            chk(tag, {31'd0, wd_flag}, {31'd0, e});
            chk({tag, " R6 irq"}, {31'd0, wd_irq}, {31'd0, e});
            if (wd_flag) wr(2'd3, 12'h001);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [RW-1:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 flag", {31'd0, wd_flag}, 0);
        chk("R1 irq", {31'd0, wd_irq}, 0);
        rst_n = 1'b1;
        rd(2'd0, d); chk("R1 low", d, 0);
        rd(2'd1, d); chk("R1 high", d, 12'hfff);
        rd(2'd2, d); chk("R1 ctrl", d, 0);

        // R2: write and read back
        wr(2'd0, 12'h123); rd(2'd0, d); chk("R2 low", d, 12'h123);
        wr(2'd1, 12'habc); rd(2'd1, d); chk("R2 high", d, 12'habc);
        wr(2'd2, ctrl(1, 0, 1, 1, 4'd0)); rd(2'd2, d); chk("R2 ctrl", d, 12'h00d);

        // R3 / R6 / R9 sweeps over every code
        sweep(100, 3000, "R3 wide");
        sweep(2000, 2000, "R3 equal");
        sweep(3000, 100, "R9 inverted");

        wr(2'd0, 12'd100); wr(2'd1, 12'd3000); wr(2'd3, 12'h001);

        // R11: data without strobe ignored
        @(negedge clk); res_valid = 1'b0; res_data = 12'd5;
        @(negedge clk);
        chk("R11 no strobe", {31'd0, wd_flag}, 0);

        // R4: sticky; R10 readback
        send(12'd4000, 0, 0);
        send(12'd500, 0, 0);
        send(12'd100, 0, 0);
        chk("R4 sticky", {31'd0, wd_flag}, 1);
        rd(2'd3, d); chk("R10 status", d, 12'h001);

        // R5: write 0 no effect, write 1 clears
        wr(2'd3, 12'h000);
        chk("R5 zero write", {31'd0, wd_flag}, 1);
        wr(2'd3, 12'h001);
        chk("R5 clear", {31'd0, wd_flag}, 0);
        rd(2'd3, d); chk("R10 status clear", d, 0);

        // R5: set wins over clear
        @(negedge clk);
        res_valid = 1'b1; res_data = 12'd7; res_chan = 0; res_inj = 0;
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 12'h001;
        @(negedge clk);
        res_valid = 1'b0; reg_wr = 1'b0;
        chk("R5 set beats clear", {31'd0, wd_flag}, 1);
        wr(2'd3, 12'h001);

        // R6: irq disabled
        wr(2'd2, ctrl(1, 0, 1, 0, 4'd0));
        send(12'd4001, 0, 0);
        chk("R6 no irq flag", {31'd0, wd_flag}, 1);
        chk("R6 no irq", {31'd0, wd_irq}, 0);
        wr(2'd3, 12'h001);

        // R7: channel filter
        wr(2'd2, ctrl(1, 0, 0, 1, 4'd5));
        send(12'd4001, 4'd4, 0);
        chk("R7 other chan", {31'd0, wd_flag}, 0);
        send(12'd4001, 4'd5, 0);
        chk("R7 guarded chan", {31'd0, wd_flag}, 1);
        wr(2'd3, 12'h001);
        wr(2'd2, ctrl(1, 0, 1, 1, 4'd5));
        send(12'd4001, 4'd4, 0);
        chk("R7 all chans", {31'd0, wd_flag}, 1);
        wr(2'd3, 12'h001);

        // R8: kind filter
        wr(2'd2, ctrl(1, 0, 1, 1, 4'd0));
        send(12'd1, 0, 1);
        chk("R8 inj ignored", {31'd0, wd_flag}, 0);
        wr(2'd2, ctrl(0, 1, 1, 1, 4'd0));
        send(12'd1, 0, 0);
        chk("R8 reg ignored", {31'd0, wd_flag}, 0);
        send(12'd1, 0, 1);
        chk("R8 inj watched", {31'd0, wd_flag}, 1);
        chk("R8 inj irq", {31'd0, wd_irq}, 1);
        @(negedge clk);
        chk("R6 pulse ends", {31'd0, wd_irq}, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule